// File: doc/BRIEF.md
# Local Interrupt Input Channel

This block serves one programmable local interrupt input of a processor-side interrupt controller. It samples an asynchronous interrupt pin through a synchronizer and recognises requests according to a configured polarity and trigger style. It holds a pending flag and offers the configured vector and delivery type to a downstream acceptor over a valid/ready handshake.

One 32-bit configuration word, written and read only as a whole word, sets the vector, the delivery type, the polarity, the trigger style and a mask. The mask holds back ordinary deliveries but never the non-maskable type. For level-triggered requests the channel keeps an acknowledge flag. The flag is set when the acceptor takes the interrupt and cleared by an end-of-interrupt pulse. While it is set, the same level cannot request the same interrupt again.

Top module: `lint_channel`

## Requirements
- R1: A write stores the vector in bits 7:0, the delivery type in bits 11:8, polarity in bit 13, trigger style in bit 15 and mask in bit 16. A read returns them at the same positions. `dlv_vector` and `dlv_type` always show the stored vector and type.
- R2: After reset the configuration word reads 32'h0001_0000, so the channel starts masked, with pending and acknowledge both clear and `dlv_valid` low.
- R3: Bit 12 (pending) and bit 14 (acknowledge) are read-only, and writes to them have no effect. Bits 31:17 read as zero.
- R4: In edge mode (bit 15 = 0) a transition of the pin to its active level sets pending. The flag becomes readable on the third rising edge after the pin changes. Holding the pin active does not set it again.
- R5: A handshake (`dlv_valid` and `dlv_ready` both high at a rising edge) clears pending. If a new edge is detected in that same cycle, pending stays set.
- R6: In level mode (bit 15 = 1), pending is set while the pin is active and acknowledge is clear. A handshake sets acknowledge, and no further request is raised while acknowledge stays set.
- R7: An `eoi_pulse` clears acknowledge on the next edge. If the pin is still active, pending is set again on the edge after that.
- R8: With the mask set and a delivery type other than 4'b0100, `dlv_valid` stays low and pending is kept. Clearing the mask then presents the held request.
- R9: With delivery type 4'b0100 (non-maskable), a pending request is presented even while the mask is set.
- R10: Bit 13 = 1 makes low the active level. Changing polarity alone never produces an edge.
- R11: A handshake and an `eoi_pulse` in the same level-mode cycle leave acknowledge set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration word with live pending and acknowledge bits |
| irq_pin | input | 1 | Asynchronous interrupt pin |
| eoi_pulse | input | 1 | End-of-interrupt pulse, one cycle |
| dlv_valid | output | 1 | Interrupt offered downstream |
| dlv_ready | input | 1 | Downstream acceptance |
| dlv_vector | output | 8 | Vector to deliver |
| dlv_type | output | 4 | Delivery type |

## Verification
Two events can fall into the same cycle. The first collision is an edge-mode acceptance that coincides with a fresh edge. The bench raises the pin again and drives ready so that it is high exactly in the cycle where the new edge is seen. It then judges that pending is still set and valid is still high. The second collision is a level-mode acceptance that meets an end-of-interrupt pulse. Ready and the end-of-interrupt pulse are driven together, and acknowledge must read as set afterwards.

// File: rtl/lintv_pkg.sv
package lintv_pkg;
    localparam int REG_W    = 32;
    localparam int VEC_W    = 8;
    localparam int TYPE_W   = 4;
    localparam int TYPE_LSB = 8;
    localparam int PEND_BIT = 12;
    localparam int POL_BIT  = 13;
    localparam int ACK_BIT  = 14;
    localparam int TRIG_BIT = 15;
    localparam int MASK_BIT = 16;

    localparam logic [TYPE_W-1:0] TYPE_NMI = 4'b0100;

    typedef enum logic {TRIG_EDGE = 1'b0, TRIG_LEVEL = 1'b1} trig_e;

    typedef struct packed {
        logic              mask;
        trig_e             trig;
        logic              active_low;
        logic [TYPE_W-1:0] dtype;
        logic [VEC_W-1:0]  vector;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{mask: 1'b1, trig: TRIG_EDGE,
                                   active_low: 1'b0, dtype: '0, vector: '0};

    function automatic cfg_t word_to_cfg(input logic [REG_W-1:0] w);
        cfg_t c;
        c.vector     = w[VEC_W-1:0];
        c.dtype      = w[TYPE_LSB +: TYPE_W];
        c.active_low = w[POL_BIT];
        c.trig       = trig_e'(w[TRIG_BIT]);
        c.mask       = w[MASK_BIT];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] cfg_to_word(input cfg_t c, input logic pend,
                                                     input logic ack);
        logic [REG_W-1:0] w;
        w                      = '0;
        w[VEC_W-1:0]           = c.vector;
        w[TYPE_LSB +: TYPE_W]  = c.dtype;
        w[PEND_BIT]            = pend;
        w[POL_BIT]             = c.active_low;
        w[ACK_BIT]             = ack;
        w[TRIG_BIT]            = c.trig;
        w[MASK_BIT]            = c.mask;
        return w;
    endfunction

    function automatic logic unmaskable(input logic [TYPE_W-1:0] t);
        return t == TYPE_NMI;
    endfunction
endpackage

// File: rtl/lintv_pin_sync.sv
module lintv_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    input  logic active_low,
    output logic active,
    output logic rise
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] shreg;
    logic              prev_raw;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) shreg <= '0;
                else     shreg <= pin;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) shreg <= '0;
                else     shreg <= {shreg[STAGES-2:0], pin};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_raw <= 1'b0;
        else     prev_raw <= shreg[LAST];
    end

    // Previous level is judged with the current polarity, so a polarity
    // change alone cannot look like a transition.
    assign active = shreg[LAST] ^ active_low;
    assign rise   = active & ~(prev_raw ^ active_low);

    // R4: a detected edge lasts one cycle only
    p_rise_single_r4: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);
endmodule

// File: rtl/lintv_cfg_reg.sv
module lintv_cfg_reg
    import lintv_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    output cfg_t             cfg
);
    always_ff @(posedge clk) begin
        if (rst)     cfg <= CFG_RESET;
        else if (we) cfg <= word_to_cfg(wdata);
    end

    // R1: a write lands in the stored fields on the next edge
    p_write_store_r1: assert property (@(posedge clk) disable iff (rst)
        we |=> (cfg.vector == $past(wdata[VEC_W-1:0]))
            && (cfg.dtype == $past(wdata[TYPE_LSB +: TYPE_W]))
            && (cfg.mask == $past(wdata[MASK_BIT])));

    // R1: without a write the configuration holds
    p_cfg_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(cfg));
endmodule

// File: rtl/lintv_pend_ctrl.sv
module lintv_pend_ctrl
    import lintv_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cfg_t cfg,
    input  logic active,
    input  logic rise,
    input  logic ready,
    input  logic eoi,
    output logic valid,
    output logic pend,
    output logic ack
);
    logic level_mode;
    logic accept;
    logic set_req;

    assign level_mode = (cfg.trig == TRIG_LEVEL);
    assign valid      = pend & (~cfg.mask | unmaskable(cfg.dtype));
    assign accept     = valid & ready;
    assign set_req    = level_mode ? (active & ~ack & ~accept) : rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= 1'b0;
            ack  <= 1'b0;
        end else begin
            pend <= set_req | (pend & ~accept);
            if (accept && level_mode) ack <= 1'b1;
            else if (eoi)             ack <= 1'b0;
        end
    end

    // R8: a masked ordinary type is never offered
    p_mask_block_r8: assert property (@(posedge clk) disable iff (rst)
        (cfg.mask && !unmaskable(cfg.dtype)) |-> !valid);

    // R5: acceptance without a coinciding edge clears pending
    p_accept_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (valid && ready && !(rise && !level_mode)) |=> !pend);

    // R6: level acceptance sets acknowledge
    p_ack_set_r6: assert property (@(posedge clk) disable iff (rst)
        (valid && ready && level_mode) |=> ack);

    // R7: end-of-interrupt without acceptance clears acknowledge
    p_eoi_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (eoi && !(valid && ready && level_mode)) |=> !ack);
endmodule

// File: rtl/lint_channel.sv
module lint_channel
    import lintv_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              irq_pin,
    input  logic              eoi_pulse,
    output logic              dlv_valid,
    input  logic              dlv_ready,
    output logic [7:0]        dlv_vector,
    output logic [3:0]        dlv_type
);
    cfg_t cfg;
    logic active;
    logic rise;
    logic pend;
    logic ack;

    lintv_cfg_reg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    lintv_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .pin        (irq_pin),
        .active_low (cfg.active_low),
        .active     (active),
        .rise       (rise)
    );

    lintv_pend_ctrl u_pend (
        .clk    (clk),
        .rst    (rst),
        .cfg    (cfg),
        .active (active),
        .rise   (rise),
        .ready  (dlv_ready),
        .eoi    (eoi_pulse),
        .valid  (dlv_valid),
        .pend   (pend),
        .ack    (ack)
    );

    assign cfg_rdata  = cfg_to_word(cfg, pend, ack);
    assign dlv_vector = cfg.vector;
    assign dlv_type   = cfg.dtype;

    // R3: unused upper bits never read as one
    p_reserved_zero_r3: assert property (@(posedge clk) disable iff (rst)
        cfg_rdata[31:17] == '0);

    // R9: a pending non-maskable type is offered regardless of mask
    p_nmi_offer_r9: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdata[12] && dlv_type == 4'b0100) |-> dlv_valid);
endmodule

// File: tb/sim_lint_channel.sv
`timescale 1ns/1ps
module sim_lint_channel;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        irq_pin = 1'b0;
    logic        eoi_pulse = 1'b0;
    logic        dlv_valid;
    logic        dlv_ready = 1'b0;
    logic [7:0]  dlv_vector;
    logic [3:0]  dlv_type;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    lint_channel u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .irq_pin(irq_pin), .eoi_pulse(eoi_pulse),
        .dlv_valid(dlv_valid), .dlv_ready(dlv_ready),
        .dlv_vector(dlv_vector), .dlv_type(dlv_type)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [31:0] d);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = d;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic take;
        @(negedge clk); dlv_ready = 1'b1;
        @(negedge clk); dlv_ready = 1'b0;
    endtask

    task automatic t_reset;
        check("R2 reset word", cfg_rdata, 32'h0001_0000);
        check("R2 reset valid", {31'b0, dlv_valid}, 0);
    endtask

    task automatic t_fields;
        wr(32'hFFFF_5FFF);
        check("R1 R3 readback", cfg_rdata, 32'h0001_0FFF);
        check("R1 vector out", {24'b0, dlv_vector}, 32'hFF);
        check("R1 type out", {28'b0, dlv_type}, 32'hF);
        cyc(5);
        check("R3 pend/ack unwritten", cfg_rdata, 32'h0001_0FFF);
    endtask

    task automatic t_edge;
        wr(32'h0000_0042);
        irq_pin = 1'b1;
        cyc(2);
        check("R4 latency not yet", {31'b0, cfg_rdata[12]}, 0);
        cyc(1);
        check("R4 pending set", {31'b0, cfg_rdata[12]}, 1);
        check("R4 valid", {31'b0, dlv_valid}, 1);
        check("R1 vector 42", {24'b0, dlv_vector}, 32'h42);
        take();
        check("R5 accept clears", {31'b0, cfg_rdata[12]}, 0);
        cyc(4);
        check("R4 held pin no repeat", {31'b0, cfg_rdata[12]}, 0);
        irq_pin = 1'b0;
        cyc(4);
    endtask

    task automatic t_collide;
        irq_pin = 1'b1; cyc(4);
        irq_pin = 1'b0; cyc(4);
        check("R5 pend before collide", {31'b0, cfg_rdata[12]}, 1);
        irq_pin = 1'b1;
        cyc(2);
        dlv_ready = 1'b1;
        cyc(1);
        dlv_ready = 1'b0;
        check("R5 edge with accept keeps pend", {31'b0, cfg_rdata[12]}, 1);
        check("R5 still valid", {31'b0, dlv_valid}, 1);
        take();
        check("R5 later accept clears", {31'b0, cfg_rdata[12]}, 0);
        irq_pin = 1'b0; cyc(4);
    endtask

    task automatic t_mask;
        wr(32'h0001_0033);
        irq_pin = 1'b1; cyc(4); irq_pin = 1'b0;
        check("R8 pending held", {31'b0, cfg_rdata[12]}, 1);
        check("R8 masked no valid", {31'b0, dlv_valid}, 0);
        dlv_ready = 1'b1; cyc(3); dlv_ready = 1'b0;
        check("R8 pend survives ready", {31'b0, cfg_rdata[12]}, 1);
        wr(32'h0000_0033);
        check("R8 unmask offers", {31'b0, dlv_valid}, 1);
        take();
        check("R8 taken", {31'b0, cfg_rdata[12]}, 0);
        cyc(3);
    endtask

    task automatic t_nmi;
        wr(32'h0001_0455);
        irq_pin = 1'b1; cyc(4); irq_pin = 1'b0;
        check("R9 nmi valid under mask", {31'b0, dlv_valid}, 1);
        check("R9 nmi type", {28'b0, dlv_type}, 32'h4);
        take();
        check("R9 nmi taken", {31'b0, cfg_rdata[12]}, 0);
        cyc(3);
    endtask

    task automatic t_pol;
        wr(32'h0000_2066);
        cyc(4);
        check("R10 polarity change no edge", {31'b0, cfg_rdata[12]}, 0);
        irq_pin = 1'b1; cyc(4);
        check("R10 high inactive", {31'b0, cfg_rdata[12]}, 0);
        irq_pin = 1'b0; cyc(4);
        check("R10 low edge pends", {31'b0, cfg_rdata[12]}, 1);
        take();
        check("R10 taken", {31'b0, cfg_rdata[12]}, 0);
    endtask

    task automatic t_level;
        wr(32'h0000_8077);
        irq_pin = 1'b1; cyc(4);
        check("R6 level pends", {31'b0, cfg_rdata[12]}, 1);
        take();
        check("R6 ack set", {31'b0, cfg_rdata[14]}, 1);
        check("R6 pend cleared", {31'b0, cfg_rdata[12]}, 0);
        cyc(5);
        check("R6 no repeat while ack", {31'b0, dlv_valid}, 0);
        @(negedge clk); eoi_pulse = 1'b1;
        @(negedge clk); eoi_pulse = 1'b0;
        check("R7 eoi clears ack", {31'b0, cfg_rdata[14]}, 0);
        cyc(1);
        check("R7 re-request", {31'b0, cfg_rdata[12]}, 1);
        @(negedge clk); dlv_ready = 1'b1; eoi_pulse = 1'b1;
        @(negedge clk); dlv_ready = 1'b0; eoi_pulse = 1'b0;
        check("R11 ack wins over eoi", {31'b0, cfg_rdata[14]}, 1);
        irq_pin = 1'b0; cyc(3);
        @(negedge clk); eoi_pulse = 1'b1;
        @(negedge clk); eoi_pulse = 1'b0;
        cyc(4);
        check("R7 inactive pin no request", {31'b0, cfg_rdata[12]}, 0);
    endtask

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc(1);
        t_reset();
        t_fields();
        t_edge();
        t_collide();
        t_mask();
        t_nmi();
        t_pol();
        t_level();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule